// File: doc/BRIEF.md
# Ring Tone Sine Synthesizer Controller

This block turns a fixed system clock into a stream of signed sine samples for a telephone ringing generator. The sine is produced by a phase counter that advances in fixed steps. A full output cycle has 2^PH_W steps. The interval between steps is a whole number of clock cycles chosen by a 3-bit frequency code. A quarter-wave shape function gives the sample magnitude, and the quadrant of the phase sets the mirroring and the sign. A 2-bit amplitude code then scales the sample. A 2-bit offset select code is carried along so that downstream logic can pick a DC level. The block outputs the code that is currently active.

Control changes are applied only at phase crossings, so the ring waveform stays clean. The frequency, amplitude and offset codes move into the active set only when the phase passes 0 or 180 degrees. An enable always starts the wave from phase 0. A mute-to-audible amplitude change also restarts the wave from phase 0. When enable drops, the wave stops at once or at the next crossing, depending on a mode bit. The block also produces a sync pulse for ringing relays. The pulse rises a programmable number of clock cycles before each crossing and drops at the crossing itself.

Top module: `ring_sine_synth`

## Requirements
- R1: While running, the phase advances by one step every D clock cycles, with D = CLK_HZ / (2^PH_W · f). The frequency f is selected by `freq_i` with bit 0 as LSB: 0→16 2/3 Hz, 1→20, 2→25, 3→30, 4→33 1/3, 5→40, 6→50, 7→60. At the defaults D is 36, 30, 24, 20, 18, 15, 12, 10. One half cycle therefore lasts 2^(PH_W-1)·D cycles.
- R2: For phase p, quadrant q = p[PH_W-1:PH_W-2] and i = p[PH_W-3:0]. Let N = 2^(PH_W-2), t = i when q[0]=0 and t = N−i otherwise. The magnitude is m = ⌊FS·t·(3N²−t²) / (2N³)⌋, with FS = 2^(SAMPLE_W-1)−1. The unscaled sample is m when q[1]=0 and −m when q[1]=1.
- R3: The amplitude code scales the unscaled sample v to trunc(v·k/4), with k = 0 for code 00, 2 for code 01, 3 for code 10 and 4 for code 11. Truncation is toward zero.
- R4: A new frequency, amplitude or offset code becomes active only at the clock edge where the phase reaches a multiple of 2^(PH_W-1) (the 0° or 180° crossing), or when the wave starts or restarts.
- R5: The control capture stage copies `freq_i`, `amp_i`, `off_i` and `en_i` on every clock edge at which `le_i` is high. It holds them while `le_i` is low. The block acts on the captured copy.
- R6: When the captured enable is high while the wave is stopped, the next edge starts the wave at phase 0 with all codes loaded from the capture stage. The first running sample is 0.
- R7: When the wave is running with active amplitude 00 and the captured amplitude is nonzero, the next edge restarts the wave at phase 0 with all codes loaded.
- R8: With `sync_mode_i` = 0, a low captured enable stops the wave at the next edge. Once stopped, the sample output is 0.
- R9: With `sync_mode_i` = 1, a low captured enable lets the wave run on until the next crossing edge, where it stops.
- R10: While running, `sync_o` is high when the remaining cycles to the next crossing edge, (2^(PH_W-1) − p mod 2^(PH_W-1))·D − c, are at most `lead_i`. Here c is the cycle count within the current step. `sync_o` is low in the cycle that follows a crossing or a start. With a lead longer than a half cycle, the pulse is high from the second cycle after a crossing.
- R11: `off_o` shows the active offset select code: 00 none, 01 level 1, 10 level 2, 11 level 3.
- R12: After reset, `sample_o` is 0, `sync_o` is 0 and `off_o` is 00, and the wave is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (19.6608 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| le_i | input | 1 | Capture enable for the control inputs |
| freq_i | input | 3 | Ring frequency code |
| amp_i | input | 2 | Amplitude code |
| off_i | input | 2 | DC offset select code |
| en_i | input | 1 | Ring output enable |
| sync_mode_i | input | 1 | 0: stop at once, 1: stop at next crossing |
| lead_i | input | LEAD_W | Sync lead time in clock cycles |
| sample_o | output | SAMPLE_W | Signed scaled sine sample |
| off_o | output | 2 | Active offset select code |
| sync_o | output | 1 | Crossing sync pulse |

## Verification
The assertions assume that all inputs are synchronous to the clock and settle well before each edge. They also assume that reset is held across at least one edge at start-up. The stimulus meets both by changing inputs one time unit after a rising edge and by releasing reset only after several edges. The bench uses a reduced phase width and a matching clock value, so the divisors stay those of R1 while half cycles shrink to a few thousand cycles. This lets every code change, restart and stop meet many crossings within the run.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef struct packed {
    logic [2:0] freq;
    logic [1:0] amp;
    logic [1:0] off;
    logic       en;
  } ring_ctl_t;

  // ring frequency times three, so every entry is an integer
  function automatic longint freq_x3(input int code);
    case (code)
      0:       return 50;
      1:       return 60;
      2:       return 75;
      3:       return 90;
      4:       return 100;
      5:       return 120;
      6:       return 150;
      default: return 180;
    endcase
  endfunction

  // clock cycles per phase step
  function automatic int div_of(input int code, input longint clk_hz, input int ph_w);
    return int'((clk_hz * 3) / ((longint'(1) << ph_w) * freq_x3(code)));
  endfunction

  // quarter-wave magnitude, cubic shape over t in [0, 2^qa]
  function automatic longint quarter_sine(input longint t, input int qa, input longint fs);
    longint n;
    n = longint'(1) << qa;
    return (fs * (3 * t * n * n - t * t * t)) / (2 * n * n * n);
  endfunction

  // amplitude code scaling, truncating toward zero
  function automatic longint scale_amp(input longint v, input int code);
    longint k;
    case (code)
      0:       k = 0;
      1:       k = 2;
      2:       k = 3;
      default: k = 4;
    endcase
    return (v * k) / 4;
  endfunction

  // clock edges left until the next crossing edge
  function automatic longint cross_cycles(input longint steps_left, input longint div,
                                          input longint cnt);
    return steps_left * div - cnt;
  endfunction

endpackage

// File: rtl/ring_ctl_capture.sv
module ring_ctl_capture
  import ring_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      le_i,
  input  ring_ctl_t d_i,
  output ring_ctl_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (le_i) q_o <= d_i;
  end

  // R5
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> $stable(q_o));

  // R5
  cap_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q_o == $past(d_i)));

endmodule

// File: rtl/ring_phase_engine.sv
module ring_phase_engine
  import ring_pkg::*;
#(
  parameter longint CLK_HZ = 19660800,
  parameter int     PH_W   = 15,
  parameter int     CNT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ring_ctl_t        ctl_i,
  input  logic             mode_i,
  output logic             run_o,
  output logic [PH_W-1:0]  phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] div_o,
  output logic [1:0]       amp_o,
  output logic [1:0]       off_o,
  output logic             xing_o
);

  logic             run_q;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       freq_q;
  logic [1:0]       amp_q;
  logic [1:0]       off_q;

  logic [CNT_W-1:0] div_w;
  logic             step_w;
  logic             xing_w;
  logic             start_w;
  logic             stop_now_w;
  logic             stop_x_w;
  logic             load_w;

  always_comb begin
    div_w      = CNT_W'(div_of(int'(freq_q), CLK_HZ, PH_W));
    step_w     = run_q && (cnt_q == div_w - CNT_W'(1));
    xing_w     = step_w && (&ph_q[PH_W-2:0]);
    start_w    = ctl_i.en && (!run_q || (amp_q == 2'd0 && ctl_i.amp != 2'd0));
    stop_now_w = run_q && !ctl_i.en && !mode_i;
    stop_x_w   = run_q && !ctl_i.en && mode_i && xing_w;
    load_w     = start_w || (xing_w && !stop_now_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (start_w) begin
      run_q <= 1'b1;
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (stop_now_w) begin
      run_q <= 1'b0;
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (step_w) begin
        ph_q  <= ph_q + PH_W'(1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (stop_x_w) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      amp_q  <= '0;
      off_q  <= '0;
    end else if (load_w) begin
      freq_q <= ctl_i.freq;
      amp_q  <= ctl_i.amp;
      off_q  <= ctl_i.off;
    end
  end

  assign run_o   = run_q;
  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
  assign div_o   = div_w;
  assign amp_o   = amp_q;
  assign off_o   = off_q;
  assign xing_o  = xing_w;

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < div_w));

  // R4
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_q != $past(freq_q) || amp_q != $past(amp_q) || off_q != $past(off_q))
      |-> $past(load_w));

  // R6
  start_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && ctl_i.en) |=> (run_q && ph_q == '0 && cnt_q == '0));

  // R8
  stop_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ctl_i.en && !mode_i) |=> !run_q);

  // R9
  wind_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ctl_i.en && mode_i && !xing_w) |=> run_q);

endmodule

// File: rtl/ring_wave_shaper.sv
module ring_wave_shaper
  import ring_pkg::*;
#(
  parameter int PH_W     = 15,
  parameter int SAMPLE_W = 12,
  parameter int LEAD_W   = 24,
  parameter int CNT_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic [PH_W-1:0]            phase_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [CNT_W-1:0]           div_i,
  input  logic [1:0]                 amp_i,
  input  logic [LEAD_W-1:0]          lead_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sync_o
);

  localparam int     QA   = PH_W - 2;
  localparam longint FS   = (longint'(1) << (SAMPLE_W - 1)) - 1;
  localparam longint HALF = longint'(1) << (PH_W - 1);
  localparam logic [QA:0] QFULL = {1'b1, {QA{1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] HALF_FS = SAMPLE_W'(FS / 2);

  logic [1:0]  quad;
  logic [QA:0] tq;
  logic        at_cross;
  longint      mag;
  longint      wave;
  longint      remain;

  always_comb begin
    quad     = phase_i[PH_W-1 -: 2];
    tq       = quad[0] ? (QFULL - {1'b0, phase_i[QA-1:0]}) : {1'b0, phase_i[QA-1:0]};
    mag      = quarter_sine(longint'(tq), QA, FS);
    wave     = quad[1] ? -mag : mag;
    remain   = cross_cycles(HALF - longint'(phase_i[PH_W-2:0]), longint'(div_i),
                            longint'(cnt_i));
    at_cross = (phase_i[PH_W-2:0] == '0) && (cnt_i == '0);
    sample_o = run_i ? SAMPLE_W'(scale_amp(wave, int'(amp_i))) : '0;
    sync_o   = run_i && !at_cross && (remain <= longint'(lead_i));
  end

  // R2
  first_half_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !phase_i[PH_W-1]) |-> !sample_o[SAMPLE_W-1]);

  // R3
  half_amp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && amp_i == 2'd1) |-> (sample_o <= HALF_FS && sample_o >= -HALF_FS));

endmodule

// File: rtl/ring_sine_synth.sv
module ring_sine_synth
  import ring_pkg::*;
#(
  parameter longint CLK_HZ   = 19660800,
  parameter int     PH_W     = 15,
  parameter int     SAMPLE_W = 12,
  parameter int     LEAD_W   = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       le_i,
  input  logic [2:0]                 freq_i,
  input  logic [1:0]                 amp_i,
  input  logic [1:0]                 off_i,
  input  logic                       en_i,
  input  logic                       sync_mode_i,
  input  logic [LEAD_W-1:0]          lead_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic [1:0]                 off_o,
  output logic                       sync_o
);

  localparam int DIV_MAX = div_of(0, CLK_HZ, PH_W);
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  ring_ctl_t        ctl_in;
  ring_ctl_t        ctl_cap;
  logic             run_w;
  logic [PH_W-1:0]  phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] div_w;
  logic [1:0]       amp_act;
  logic             xing_w;

  assign ctl_in = '{freq: freq_i, amp: amp_i, off: off_i, en: en_i};

  ring_ctl_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .d_i    (ctl_in),
    .q_o    (ctl_cap)
  );

  ring_phase_engine #(
    .CLK_HZ (CLK_HZ),
    .PH_W   (PH_W),
    .CNT_W  (CNT_W)
  ) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_cap),
    .mode_i  (sync_mode_i),
    .run_o   (run_w),
    .phase_o (phase_w),
    .cnt_o   (cnt_w),
    .div_o   (div_w),
    .amp_o   (amp_act),
    .off_o   (off_o),
    .xing_o  (xing_w)
  );

  ring_wave_shaper #(
    .PH_W     (PH_W),
    .SAMPLE_W (SAMPLE_W),
    .LEAD_W   (LEAD_W),
    .CNT_W    (CNT_W)
  ) u_shape (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .phase_i  (phase_w),
    .cnt_i    (cnt_w),
    .div_i    (div_w),
    .amp_i    (amp_act),
    .lead_i   (lead_i),
    .sample_o (sample_o),
    .sync_o   (sync_o)
  );

  // R10
  sync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xing_w |=> !sync_o);

  // R8
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |-> (sample_o == '0 && !sync_o));

endmodule

// File: tb/ring_sine_synth_test.sv
module ring_sine_synth_test;

  localparam int     CLK_PERIOD = 10;
  localparam int     PH         = 8;
  localparam longint CLK        = 153600;
  localparam int     SW         = 12;
  localparam int     LW         = 24;
  localparam longint FSB        = 2047;
  localparam int     HALFB      = 128;
  localparam longint NQ         = 64;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 le = 1'b0;
  logic [2:0]           freq = '0;
  logic [1:0]           amp = '0;
  logic [1:0]           off = '0;
  logic                 en = 1'b0;
  logic                 smode = 1'b0;
  logic [LW-1:0]        lead = '0;
  logic signed [SW-1:0] sample;
  logic [1:0]           off_o;
  logic                 sync;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  int m_run = 0, m_ph = 0, m_cnt = 0, m_f = 0, m_a = 0, m_o = 0;
  int c_f = 0, c_a = 0, c_o = 0, c_en = 0;

  ring_sine_synth #(.CLK_HZ(CLK), .PH_W(PH), .SAMPLE_W(SW), .LEAD_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .le_i(le), .freq_i(freq), .amp_i(amp), .off_i(off),
    .en_i(en), .sync_mode_i(smode), .lead_i(lead), .sample_o(sample), .off_o(off_o),
    .sync_o(sync)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int bdiv(input int code);
    int hz3 [8] = '{50, 60, 75, 90, 100, 120, 150, 180};
    return int'((CLK * 3) / (longint'(256) * hz3[code]));
  endfunction

  function automatic longint exp_sample();
    longint t, m, w;
    int quadrant, r;
    if (m_run == 0) return 0;
    quadrant = m_ph / 64;
    r = m_ph % 64;
    t = (quadrant % 2 == 1) ? NQ - r : r;
    m = (FSB * t * (3 * NQ * NQ - t * t)) / (2 * NQ * NQ * NQ);
    w = (quadrant >= 2) ? -m : m;
    case (m_a)
      0: return 0;
      1: return (2 * w) / 4;
      2: return (3 * w) / 4;
      default: return w;
    endcase
  endfunction

  function automatic longint exp_sync();
    longint left;
    if (m_run == 0) return 0;
    if (m_ph % HALFB == 0 && m_cnt == 0) return 0;
    left = longint'(HALFB - m_ph % HALFB) * bdiv(m_f) - m_cnt;
    return (left <= longint'(lead)) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_cnt = 0; m_f = 0; m_a = 0; m_o = 0;
      c_f = 0; c_a = 0; c_o = 0; c_en = 0;
    end else begin
      int d;
      bit stp, xg, st, sn;
      d   = bdiv(m_f);
      stp = (m_run != 0) && (m_cnt == d - 1);
      xg  = stp && (m_ph % HALFB == HALFB - 1);
      st  = (c_en != 0) && (m_run == 0 || (m_a == 0 && c_a != 0));
      sn  = (m_run != 0) && (c_en == 0) && !smode;
      if (st) begin
        m_run = 1; m_ph = 0; m_cnt = 0; m_f = c_f; m_a = c_a; m_o = c_o;
      end else if (sn) begin
        m_run = 0; m_ph = 0; m_cnt = 0;
      end else if (m_run != 0) begin
        if (stp) begin
          m_ph = (m_ph + 1) % 256;
          m_cnt = 0;
          if (xg) begin
            m_f = c_f; m_a = c_a; m_o = c_o;
            if (c_en == 0 && smode) m_run = 0;
          end
        end else begin
          m_cnt++;
        end
      end
      if (le) begin
        c_f = freq; c_a = amp; c_o = off; c_en = en;
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 R3 sample", longint'(sample), exp_sample());
      check("R10 sync", longint'(sync), exp_sync());
      check("R11 offset", longint'(off_o), longint'(m_o));
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_sync_fall(output int cycles);
    logic prev;
    cycles = 0;
    prev = sync;
    forever begin
      @(negedge clk);
      cycles++;
      if (prev && !sync) break;
      prev = sync;
    end
  endtask

  initial begin
    int cyc;
    longint smax, smin;
    edges(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset sample", longint'(sample), 0);
    check("R12 reset sync", longint'(sync), 0);
    check("R12 reset offset", longint'(off_o), 0);

    // start at 60 Hz, full amplitude
    edges(1);
    le = 1'b1; freq = 3'd7; amp = 2'd3; off = 2'd1; en = 1'b1; lead = 24'd50;
    edges(2);
    @(negedge clk);
    check("R6 first sample at phase 0", longint'(sample), 0);
    check("R6 offset loaded at start", longint'(off_o), 1);

    wait_sync_fall(cyc);
    wait_sync_fall(cyc);
    check("R1 half cycle code 7", cyc, 128 * 10);
    smax = -100000; smin = 100000;
    for (int i = 0; i < 2 * 1280; i++) begin
      @(negedge clk);
      if (sample > smax) smax = sample;
      if (sample < smin) smin = sample;
    end
    check("R2 positive peak", smax, 2047);
    check("R2 negative peak", smin, -2047);

    // deferred code change
    wait_sync_fall(cyc);
    edges(300);
    freq = 3'd0; amp = 2'd1; off = 2'd2;
    edges(5);
    check("R4 offset held before crossing", longint'(off_o), 1);
    wait_sync_fall(cyc);
    check("R4 offset applied at crossing", longint'(off_o), 2);
    wait_sync_fall(cyc);
    check("R1 half cycle code 0", cyc, 128 * 36);

    // capture closed
    edges(1);
    le = 1'b0;
    edges(1);
    off = 2'd3; amp = 2'd2; freq = 3'd5;
    wait_sync_fall(cyc);
    check("R5 offset ignored while capture closed", longint'(off_o), 2);
    wait_sync_fall(cyc);
    check("R5 period unchanged while capture closed", cyc, 128 * 36);
    edges(1);
    le = 1'b1;

    // mute then restart
    amp = 2'd0;
    wait_sync_fall(cyc);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3 mute code gives zero", longint'(sample), 0);
    end
    edges(1);
    amp = 2'd3;
    edges(2);
    @(negedge clk);
    check("R7 restart at phase 0", longint'(sample), 0);
    check("R7 sync low at restart", longint'(sync), 0);
    check("R7 codes loaded at restart", longint'(off_o), 3);
    edges(14);
    @(negedge clk);
    check("R7 still phase 0 before first step", longint'(sample), 0);
    edges(1);
    @(negedge clk);
    check("R7 first step sample", longint'(sample), 47);

    // immediate stop
    edges(100);
    en = 1'b0; smode = 1'b0;
    edges(2);
    @(negedge clk);
    check("R8 stopped sample", longint'(sample), 0);
    check("R8 stopped sync", longint'(sync), 0);
    edges(40);
    @(negedge clk);
    check("R8 stays stopped", longint'(sample), 0);

    // long lead
    edges(1);
    en = 1'b1; lead = 24'hFFFFFF;
    edges(2);
    @(negedge clk);
    check("R10 low in start cycle", longint'(sync), 0);
    @(negedge clk);
    check("R10 high right after start", longint'(sync), 1);
    wait_sync_fall(cyc);
    @(negedge clk);
    check("R10 low for one cycle only", longint'(sync), 1);

    // stop at crossing
    edges(1);
    lead = 24'd50;
    wait_sync_fall(cyc);
    edges(200);
    smode = 1'b1; en = 1'b0;
    edges(3);
    @(negedge clk);
    check("R9 still running after enable drop", longint'(sample != 0), 1);
    wait_sync_fall(cyc);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R9 silent after crossing", longint'(sample), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule